// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block holds a small fully associative table of address translations that software fills and inspects itself. Every entry maps one virtual page pair (an even and an odd 4 KiB page) to two physical frames, each with its own valid, dirty and cache-attribute fields. The entry also carries an address-space identifier (ASID) and a global flag. Software stages an entry in a set of control registers: a tag word, two frame words, a page-mask word, an index register and a wired floor. It then issues one of four single-cycle commands.

The two write commands copy the staged registers into a slot. The slot is either the one named by the index register or the one named by a free-running replacement counter. The read command copies a slot back into the staging registers. The probe command compares the staged tag against all entries in parallel. It reports the lowest matching slot in the index register, or flags a miss in bit 31 of that register. The translation lookup path for loads and stores lies outside this block.

Top module: `tlb_ctrl`

## Requirements
- R1: Write-indexed (cmd_op_i=0) stores into slot index[IDX_W-1:0] the following fields. The VPN is tag bits [31:13] and the ASID is tag bits [7:0]. The page mask is the full word. The global bit is lo_even[0] AND lo_odd[0]. For each half, valid is bit 1, dirty is bit 2, the cache attribute is bits [5:3] and the frame number is bits [31:6].
- R2: Write-random (cmd_op_i=1) stores the same fields into the slot given by random_o in the command cycle.
- R3: Read (cmd_op_i=2) of slot index[IDX_W-1:0] loads the tag register with {VPN, 5'b0, ASID} and restores the page mask. Each frame word becomes {PFN, C, D, V, G}, so the global bit appears in bit 0 of both words.
- R4: Probe (cmd_op_i=3) treats an entry as a match when its VPN equals tag[31:13] and either its global bit is set or its ASID equals tag[7:0]. On a hit, the lowest matching slot goes into index[IDX_W-1:0] and index bit 31 is cleared.
- R5: On a probe miss, index bit 31 is set and index[IDX_W-1:0] keeps its value.
- R6: random_o is NUM_ENTRIES-1 after reset. On every clock it steps down by one while it is above wired_o. When it is at or below wired_o, it reloads NUM_ENTRIES-1.
- R7: A write to the wired register (reg_sel_i=5) loads reg_wdata_i[IDX_W-1:0] and forces random_o to NUM_ENTRIES-1 on the same edge.
- R8: A write to index (reg_sel_i=4) keeps only bits [IDX_W-1:0] and bit 31. All other index bits read as zero. The other selects are: 0 tag, 1 lo_even, 2 lo_odd, 3 page mask.
- R9: A register write in the same cycle as cmd_valid_i is dropped.
- R10: Reset clears every staging register, the index, the wired floor and every entry to zero.
- R11: Every command takes effect on the clock edge where cmd_valid_i is high, so its result is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select (0 tag, 1 lo_even, 2 lo_odd, 3 pmask, 4 index, 5 wired) |
| reg_wdata_i | input | 32 | Register write data |
| cmd_valid_i | input | 1 | Command pulse |
| cmd_op_i | input | 2 | Command (0 write-indexed, 1 write-random, 2 read, 3 probe) |
| tag_o | output | 32 | Staged tag: VPN and ASID |
| lo_even_o | output | 32 | Staged even-page frame word |
| lo_odd_o | output | 32 | Staged odd-page frame word |
| pmask_o | output | 32 | Staged page mask |
| index_o | output | 32 | Index register, bit 31 = probe miss |
| random_o | output | IDX_W | Replacement counter |
| wired_o | output | IDX_W | Wired floor for the replacement counter |

## Verification
The bench uses the default 16 entries, 8-bit ASIDs and 32-bit register words. With 16 entries, the whole table can be filled and read back, and every wired floor from 0 to 15 can be tried, including the one where the counter stays pinned at 15. The random phase draws tags from a pool of four page numbers and four ASIDs. This keeps probe hits, global-only hits, duplicate matches that need the lowest-slot rule, and misses all frequent.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int REG_W   = 32;
  localparam int ASID_W  = 8;
  localparam int VPN_LSB = 13;
  localparam int PFN_LSB = 6;
  localparam int VPN_W   = REG_W - VPN_LSB;
  localparam int PFN_W   = REG_W - PFN_LSB;

  typedef enum logic [1:0] {
    CMD_WR_IDX = 2'd0,
    CMD_WR_RND = 2'd1,
    CMD_READ   = 2'd2,
    CMD_PROBE  = 2'd3
  } tlb_cmd_e;

  typedef enum logic [2:0] {
    SEL_TAG     = 3'd0,
    SEL_LO_EVEN = 3'd1,
    SEL_LO_ODD  = 3'd2,
    SEL_PMASK   = 3'd3,
    SEL_INDEX   = 3'd4,
    SEL_WIRED   = 3'd5
  } tlb_sel_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             dirty;
    logic             valid;
  } tlb_half_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [REG_W-1:0]  pmask;
    tlb_half_t         even;
    tlb_half_t         odd;
  } tlb_entry_t;

  function automatic tlb_half_t lo_to_half(logic [REG_W-1:0] lo);
    tlb_half_t h;
    h.pfn   = lo[REG_W-1:PFN_LSB];
    h.cattr = lo[5:3];
    h.dirty = lo[2];
    h.valid = lo[1];
    return h;
  endfunction

  function automatic logic [REG_W-1:0] half_to_lo(tlb_half_t h, logic g);
    return {h.pfn, h.cattr, h.dirty, h.valid, g};
  endfunction

  function automatic tlb_entry_t regs_to_entry(logic [REG_W-1:0] tag, logic [REG_W-1:0] lo0,
                                               logic [REG_W-1:0] lo1, logic [REG_W-1:0] pm);
    tlb_entry_t e;
    e.vpn   = tag[REG_W-1:VPN_LSB];
    e.asid  = tag[ASID_W-1:0];
    e.glob  = lo0[0] & lo1[0];
    e.pmask = pm;
    e.even  = lo_to_half(lo0);
    e.odd   = lo_to_half(lo1);
    return e;
  endfunction

  function automatic logic [REG_W-1:0] entry_to_tag(tlb_entry_t e);
    return {e.vpn, {(VPN_LSB-ASID_W){1'b0}}, e.asid};
  endfunction
endpackage

// File: rtl/tlb_random.sv
module tlb_random #(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wired_wr_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wired_wdata_i,
  output logic [$clog2(NUM_ENTRIES)-1:0] wired_o,
  output logic [$clog2(NUM_ENTRIES)-1:0] rnd_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rnd_q, wired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q   <= TOP;
      wired_q <= '0;
    end else if (wired_wr_i) begin
      wired_q <= wired_wdata_i;
      rnd_q   <= TOP;
    end else if (rnd_q <= wired_q) begin
      rnd_q <= TOP;
    end else begin
      rnd_q <= rnd_q - 1'b1;
    end
  end

  assign rnd_o   = rnd_q;
  assign wired_o = wired_q;

  // R6
  rnd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wired_wr_i && rnd_q > wired_q) |=> rnd_q == $past(rnd_q) - 1'b1);
  // R6
  rnd_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rnd_q >= wired_q) || (rnd_q == TOP));
  // R7
  wired_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wired_wr_i |=> rnd_q == TOP);
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0] wr_slot_i,
  input  tlb_entry_t                     wr_entry_i,
  input  logic [$clog2(NUM_ENTRIES)-1:0] rd_slot_i,
  output tlb_entry_t                     rd_entry_o,
  input  logic [VPN_W-1:0]               cmp_vpn_i,
  input  logic [ASID_W-1:0]              cmp_asid_i,
  output logic                           hit_o,
  output logic [$clog2(NUM_ENTRIES)-1:0] hit_slot_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  tlb_entry_t             mem_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_slot_i] <= wr_entry_i;
    end
  end

  assign rd_entry_o = mem_q[rd_slot_i];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign match[g] = (mem_q[g].vpn == cmp_vpn_i) &&
                      (mem_q[g].glob || (mem_q[g].asid == cmp_asid_i));
  end

  // lowest slot wins
  always_comb begin
    hit_slot_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_slot_o = IDX_W'(i);
  end

  assign hit_o = |match;

  // R4
  hit_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match[hit_slot_o]);
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_wr_i,
  input  logic [2:0]                     reg_sel_i,
  input  logic [31:0]                    reg_wdata_i,
  input  logic                           cmd_valid_i,
  input  logic [1:0]                     cmd_op_i,
  output logic [31:0]                    tag_o,
  output logic [31:0]                    lo_even_o,
  output logic [31:0]                    lo_odd_o,
  output logic [31:0]                    pmask_o,
  output logic [31:0]                    index_o,
  output logic [$clog2(NUM_ENTRIES)-1:0] random_o,
  output logic [$clog2(NUM_ENTRIES)-1:0] wired_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [REG_W-1:0] tag_q, lo_even_q, lo_odd_q, pmask_q;
  logic [IDX_W-1:0] idx_q;
  logic             miss_q;

  tlb_cmd_e   op;
  tlb_sel_e   sel;
  logic       reg_wr, wr_en, probe, hit;
  logic [IDX_W-1:0] wr_slot, hit_slot, rnd;
  tlb_entry_t rd_entry, wr_entry;

  assign op     = tlb_cmd_e'(cmd_op_i);
  assign sel    = tlb_sel_e'(reg_sel_i);
  assign reg_wr = reg_wr_i && !cmd_valid_i;
  assign wr_en  = cmd_valid_i && (op == CMD_WR_IDX || op == CMD_WR_RND);
  assign probe  = cmd_valid_i && (op == CMD_PROBE);
  assign wr_slot  = (op == CMD_WR_RND) ? rnd : idx_q;
  assign wr_entry = regs_to_entry(tag_q, lo_even_q, lo_odd_q, pmask_q);

  tlb_random #(.NUM_ENTRIES(NUM_ENTRIES)) u_random (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wired_wr_i   (reg_wr && sel == SEL_WIRED),
    .wired_wdata_i(reg_wdata_i[IDX_W-1:0]),
    .wired_o      (wired_o),
    .rnd_o        (rnd)
  );

  tlb_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_entry_i(wr_entry),
    .rd_slot_i (idx_q),
    .rd_entry_o(rd_entry),
    .cmp_vpn_i (tag_q[REG_W-1:VPN_LSB]),
    .cmp_asid_i(tag_q[ASID_W-1:0]),
    .hit_o     (hit),
    .hit_slot_o(hit_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q     <= '0;
      lo_even_q <= '0;
      lo_odd_q  <= '0;
      pmask_q   <= '0;
      idx_q     <= '0;
      miss_q    <= 1'b0;
    end else if (cmd_valid_i) begin
      if (op == CMD_READ) begin
        tag_q     <= entry_to_tag(rd_entry);
        pmask_q   <= rd_entry.pmask;
        lo_even_q <= half_to_lo(rd_entry.even, rd_entry.glob);
        lo_odd_q  <= half_to_lo(rd_entry.odd, rd_entry.glob);
      end else if (op == CMD_PROBE) begin
        if (hit) begin
          idx_q  <= hit_slot;
          miss_q <= 1'b0;
        end else begin
          miss_q <= 1'b1;
        end
      end
    end else if (reg_wr) begin
      unique case (sel)
        SEL_TAG:     tag_q     <= reg_wdata_i;
        SEL_LO_EVEN: lo_even_q <= reg_wdata_i;
        SEL_LO_ODD:  lo_odd_q  <= reg_wdata_i;
        SEL_PMASK:   pmask_q   <= reg_wdata_i;
        SEL_INDEX: begin
          idx_q  <= reg_wdata_i[IDX_W-1:0];
          miss_q <= reg_wdata_i[REG_W-1];
        end
        default: ;
      endcase
    end
  end

  assign tag_o     = tag_q;
  assign lo_even_o = lo_even_q;
  assign lo_odd_o  = lo_odd_q;
  assign pmask_o   = pmask_q;
  assign index_o   = {miss_q, {(REG_W-1-IDX_W){1'b0}}, idx_q};
  assign random_o  = rnd;

  // R4
  probe_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe && hit) |=> !index_o[REG_W-1] && index_o[IDX_W-1:0] == $past(hit_slot));
  // R5
  probe_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe && !hit) |=> index_o[REG_W-1] && $stable(index_o[IDX_W-1:0]));
  // R9
  cmd_blocks_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op != CMD_READ) |=> $stable(pmask_o) && $stable(tag_o) && $stable(lo_even_o));
  // R2
  rnd_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op == CMD_WR_RND) |-> wr_en && wr_slot == random_o);
endmodule

// File: tb/tlb_ctrl_tb.sv
`timescale 1ns/1ps
module tlb_ctrl_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] tag, lo0, lo1, pm, idx;
  logic [3:0]  rnd, wired;

  always #2.5 clk = ~clk;

  tlb_ctrl #(.NUM_ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .tag_o(tag), .lo_even_o(lo0), .lo_odd_o(lo1), .pmask_o(pm),
    .index_o(idx), .random_o(rnd), .wired_o(wired)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_hi [N], m_lo0 [N], m_lo1 [N], m_pm [N];
  logic [31:0] e_tag = 0, e_lo0 = 0, e_lo1 = 0, e_pm = 0, e_idx = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk({req, " tag"}, tag, e_tag);
    chk({req, " lo_even"}, lo0, e_lo0);
    chk({req, " lo_odd"}, lo1, e_lo1);
    chk({req, " pmask"}, pm, e_pm);
    chk({req, " index"}, idx, e_idx);
  endtask

  function automatic int probe_find(logic [31:0] t);
    for (int i = 0; i < N; i++)
      if (m_hi[i][31:13] == t[31:13] && (m_lo0[i][0] || m_hi[i][7:0] == t[7:0])) return i;
    return -1;
  endfunction

  function automatic void model_reg(logic [2:0] s, logic [31:0] d);
    case (s)
      3'd0: e_tag = d;
      3'd1: e_lo0 = d;
      3'd2: e_lo1 = d;
      3'd3: e_pm  = d;
      3'd4: e_idx = {d[31], 27'b0, d[3:0]};
      default: ;
    endcase
  endfunction

  task automatic reg_write(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    model_reg(s, d);
  endtask

  // issue command; optionally collide with a register write (R9)
  task automatic cmd(logic [1:0] op, bit collide, logic [2:0] s, logic [31:0] d, output string req);
    int slot, h;
    logic g;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op;
    reg_wr = collide; reg_sel = s; reg_wdata = d;
    slot = (op == 2'd1) ? int'(rnd) : int'(e_idx[3:0]);
    @(posedge clk); #1;
    cmd_valid = 0; reg_wr = 0;
    req = collide ? "R9" : "R11";
    case (op)
      2'd0, 2'd1: begin
        g = e_lo0[0] & e_lo1[0];
        m_hi[slot]  = (e_tag & 32'hFFFF_E000) | (e_tag & 32'hFF);
        m_lo0[slot] = {e_lo0[31:1], g};
        m_lo1[slot] = {e_lo1[31:1], g};
        m_pm[slot]  = e_pm;
        if (!collide) req = (op == 2'd0) ? "R1" : "R2";
      end
      2'd2: begin
        e_tag = m_hi[slot]; e_lo0 = m_lo0[slot]; e_lo1 = m_lo1[slot]; e_pm = m_pm[slot];
        if (!collide) req = "R3";
      end
      default: begin
        h = probe_find(e_tag);
        if (h >= 0) e_idx = {28'b0, 4'(h)};
        else e_idx[31] = 1'b1;
        if (!collide) req = (h >= 0) ? "R4" : "R5";
      end
    endcase
  endtask

  task automatic do_cmd(logic [1:0] op);
    string r;
    cmd(op, 0, 3'd0, 32'd0, r);
    chk_regs(r);
  endtask

  task automatic stage(logic [31:0] t, logic [31:0] l0, logic [31:0] l1, logic [31:0] p);
    reg_write(3'd0, t); reg_write(3'd1, l0); reg_write(3'd2, l1); reg_write(3'd3, p);
  endtask

  task automatic rnd_walk(int cycles);
    logic [3:0] prev, exp;
    for (int c = 0; c < cycles; c++) begin
      prev = rnd;
      @(posedge clk); #1;
      exp = (prev <= wired) ? 4'd15 : prev - 4'd1;
      chk("R6 random step", {28'b0, rnd}, {28'b0, exp});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string r;
    logic [31:0] pool_vpn [4];
    void'($urandom(32'h5EED_0017));
    for (int i = 0; i < N; i++) begin m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0; m_pm[i] = 0; end
    pool_vpn[0] = 32'h0000_2000; pool_vpn[1] = 32'h1234_4000;
    pool_vpn[2] = 32'h8000_0000; pool_vpn[3] = 32'hFFFF_E000;

    #12;
    // R10 reset state
    chk_regs("R10");
    chk("R10 random", {28'b0, rnd}, 32'd15);
    chk("R10 wired", {28'b0, wired}, 32'd0);
    rst_n = 1;
    @(posedge clk); #1;

    rnd_walk(40);
    reg_write(3'd5, 32'd12);
    chk("R7 reload", {28'b0, rnd}, 32'd15);
    chk("R7 wired", {28'b0, wired}, 32'd12);
    rnd_walk(20);
    reg_write(3'd5, 32'hFFFF_FFFF);
    rnd_walk(5);
    reg_write(3'd5, 32'd0);
    chk("R7 reload", {28'b0, rnd}, 32'd15);

    // R8 index padding
    reg_write(3'd4, 32'hFFFF_FFFF);
    chk("R8 index", idx, 32'h8000_000F);
    // R10 entries cleared: read slot 3
    reg_write(3'd4, 32'd3);
    stage(32'hDEAD_BEEF, 32'h1, 32'h1, 32'h55);
    do_cmd(2'd2);
    chk("R10 entry", tag, 32'd0);

    // R1 fill all slots with distinct pages
    for (int i = 0; i < N; i++) begin
      reg_write(3'd4, 32'h7FFF_FFF0 | i);
      stage(32'h4000_0000 + (i << 13) + 32'h1F00 + i, $urandom & 32'hFFFF_FFFE, $urandom, $urandom);
      do_cmd(2'd0);
    end
    // R3 read-back of every slot
    for (int i = 0; i < N; i++) begin
      reg_write(3'd4, i);
      do_cmd(2'd2);
    end
    // R4 duplicates: slots 9 and 5 share page and ASID, lowest wins
    stage(32'h1234_4033, 32'h0000_0042, 32'h0000_0043, 32'h0);
    reg_write(3'd4, 9); do_cmd(2'd0);
    reg_write(3'd4, 5); do_cmd(2'd0);
    reg_write(3'd4, 0); do_cmd(2'd3);
    chk("R4 lowest", idx, 32'd5);
    // R4 global via both words, other ASID
    stage(32'h8000_0011, 32'h1, 32'h1, 32'h0);
    reg_write(3'd4, 2); do_cmd(2'd0);
    reg_write(3'd0, 32'h8000_0022); do_cmd(2'd3);
    chk("R4 global", idx, 32'd2);
    // R5 global in one word only is not global
    stage(32'hFFFF_E011, 32'h1, 32'h0, 32'h0);
    reg_write(3'd4, 7); do_cmd(2'd0);
    reg_write(3'd0, 32'hFFFF_E022); do_cmd(2'd3);
    chk("R5 miss", idx, 32'h8000_0007);
    do_cmd(2'd2);
    chk("R3 glob bit", lo0[0], 32'd0);

    // mixed random traffic
    for (int it = 0; it < 600; it++) begin
      int a;
      a = $urandom_range(0, 9);
      if (a < 4) begin
        logic [2:0] s;
        logic [31:0] d;
        s = 3'($urandom_range(0, 4));
        d = $urandom;
        if (s == 3'd0) d = pool_vpn[$urandom_range(0, 3)] | (d & 32'h1F00) | 32'($urandom_range(0, 3));
        if (s == 3'd1 || s == 3'd2) d[0] = ($urandom_range(0, 2) == 0);
        reg_write(s, d);
        chk_regs("R8");
      end else begin
        bit col;
        col = ($urandom_range(0, 4) == 0);
        cmd(2'($urandom_range(0, 3)), col, 3'($urandom_range(0, 5)), $urandom, r);
        chk_regs(r);
        chk({r, " wired"}, {28'b0, wired}, 32'd0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule